// File: doc/BRIEF.md
# Playback Sample FIFO with DMA Request

This block sits between a 32-bit register write port and a serial DAC that asks for one audio frame at a time. Software or a DMA engine writes samples into a data register. Each write is shaped into a 24-bit word as it is written and stored in a 64-entry FIFO. The DAC side pulses a frame request and gets back a left and a right 24-bit word. The words come from one entry in mono mode or from two consecutive entries in stereo mode.

A DMA request output tells the DMA engine when to refill the FIFO. It has hysteresis: it rises when the free space reaches a programmable trigger level, and it drops once free space falls below a threshold chosen by a 2-bit code. When the FIFO cannot supply a whole frame, a policy bit picks between silence and holding the previous frame, and a sticky flag records the event. A self-clearing flush bit empties the FIFO.

The bus has three 32-bit registers at a stride of 4: control at byte address 0x04, status at 0x08 and data at 0x0C. Reads are combinational. Writes take effect on the clock edge.

Top module: `playback_sample_fifo`

## Requirements
- R1: After reset, control (0x04) reads 0, status (0x08) reads 0x40 and all outputs are 0. Control reads back the written bits 4, 5, 6, [13:8], [22:21], 24 and 26, and reads 0 in all other bits except the flush bit.
- R2: With control bit 5 = 1 (wide samples), a write to 0x0C stores data bits [31:8] as the 24-bit sample.
- R3: With control bit 5 = 0, data bits [15:0] form the upper 16 bits of the sample. The low 8 bits are zeros when control bit 24 = 0, and copies of data bit 15 when bit 24 = 1.
- R4: The FIFO holds 64 entries in write order. A data write while 64 entries are held is discarded.
- R5: On a frame request the outputs update at the next edge. In stereo (control bit 6 = 0) two entries are consumed, the first going to left and the second to right. In mono (bit 6 = 1) one entry drives both channels.
- R6: A frame request with fewer entries than the mode needs consumes nothing. The outputs become 0 when control bit 26 = 0, and hold their previous values when bit 26 = 1.
- R7: Status bits [6:0] give the free space (64 minus level). Status bit 7 is a sticky underrun flag that is set by R6 events and cleared by writing 1 to status bit 7.
- R8: Writing control with bit 0 = 1 makes bit 0 read 1 for one cycle. At the following edge the FIFO empties and bit 0 returns to 0.
- R9: While control bit 4 = 0, the DMA request is low from the next cycle on.
- R10: While bit 4 = 1, the registered DMA request drops when free space < (2 << control[22:21]), so a code of 3 gives 16. Otherwise it rises when free space >= control[13:8], and otherwise it holds. The drop condition has priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Bus write strobe |
| addr | input | 6 | Bus byte address |
| wrData | input | 32 | Bus write data |
| rdData | output | 32 | Bus read data (combinational) |
| frameReq | input | 1 | DAC frame request pulse |
| outLeft | output | 24 | Left channel sample |
| outRight | output | 24 | Right channel sample |
| drq | output | 1 | DMA request |

## Verification
On every cycle the assertions check four things:
- the level never exceeds the depth;
- a flush leaves the FIFO empty;
- a write into a full FIFO is dropped;
- DMA gating, the mono channel copy, and both underrun policies (zeros, or held outputs).

Only the bench scenarios can show the behaviours that need history:
- FIFO order across wrap-around;
- the exact 24-bit formatting of each width and fill mode;
- the hysteresis band of the DMA request, where the output depends on the path taken;
- the sticky flag and its write-1-to-clear.

// File: rtl/pbf_pkg.sv
package pbf_pkg;
  // Configuration fields held in the control register
  typedef struct packed {
    logic       repeatLast;
    logic       msbFill;
    logic [1:0] clrCnt;
    logic [5:0] trig;
    logic       mono;
    logic       wide;
    logic       drqEn;
  } cfg_t;

  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } strobe_t;
endpackage

// File: rtl/pbf_ctrl.sv
module pbf_ctrl
  import pbf_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int ADDR_W  = 6,
  parameter int LEVEL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wrData,
  input  logic               frameReq,
  input  logic [LEVEL_W-1:0] level,
  input  logic               underrunEvt,
  output cfg_t               cfg,
  output strobe_t            stb,
  output logic               drq,
  output logic [31:0]        rdData
);
  localparam logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(12);

  logic flushQ, stickyQ, drqQ;
  logic [LEVEL_W-1:0] freeSpace, clrThr;
  logic wrCtrl, wrStat;
  logic unusedWr;

  assign unusedWr  = ^wrData;
  assign wrCtrl    = wrEn && (addr == CTRL_OFS);
  assign wrStat    = wrEn && (addr == STAT_OFS);
  assign freeSpace = LEVEL_W'(DEPTH) - level;
  assign clrThr    = LEVEL_W'(2) << cfg.clrCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= '0;
      flushQ <= 1'b0;
    end else begin
      flushQ <= wrCtrl && wrData[0];
      if (wrCtrl) begin
        cfg.drqEn      <= wrData[4];
        cfg.wide       <= wrData[5];
        cfg.mono       <= wrData[6];
        cfg.trig       <= wrData[13:8];
        cfg.clrCnt     <= wrData[22:21];
        cfg.msbFill    <= wrData[24];
        cfg.repeatLast <= wrData[26];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          stickyQ <= 1'b0;
    else if (underrunEvt)               stickyQ <= 1'b1;
    else if (wrStat && wrData[7])       stickyQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   drqQ <= 1'b0;
    else if (!cfg.drqEn)                         drqQ <= 1'b0;
    else if (freeSpace < clrThr)                 drqQ <= 1'b0;
    else if (freeSpace >= LEVEL_W'(cfg.trig))    drqQ <= 1'b1;
  end

  assign drq       = drqQ;
  assign stb.push  = wrEn && (addr == DATA_OFS);
  assign stb.pop   = frameReq;
  assign stb.flush = flushQ;

  always_comb begin
    rdData = '0;
    if (addr == CTRL_OFS)
      rdData = {5'b0, cfg.repeatLast, 1'b0, cfg.msbFill, 1'b0, cfg.clrCnt, 7'b0,
                cfg.trig, 1'b0, cfg.mono, cfg.wide, cfg.drqEn, 3'b0, flushQ};
    else if (addr == STAT_OFS)
      rdData = 32'(freeSpace) | (32'(stickyQ) << 7);
  end
endmodule

// File: rtl/pbf_datapath.sv
module pbf_datapath
  import pbf_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int PTR_W   = $clog2(DEPTH),
  parameter int LEVEL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  cfg_t               cfg,
  input  logic [31:0]        wrData,
  output logic [LEVEL_W-1:0] level,
  output logic [23:0]        outLeft,
  output logic [23:0]        outRight,
  output logic               underrunEvt
);
  logic [23:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, rdPtrNext;
  logic [LEVEL_W-1:0] need, popN;
  logic pushOk, canPop;
  logic [23:0] shaped;
  logic unusedCfg;

  assign unusedCfg = ^{cfg.drqEn, cfg.trig, cfg.clrCnt};
  assign need      = cfg.mono ? LEVEL_W'(1) : LEVEL_W'(2);
  assign pushOk    = stb.push && (level != LEVEL_W'(DEPTH));
  assign canPop    = stb.pop && (level >= need);
  assign popN      = canPop ? need : '0;
  assign rdPtrNext = rdPtr + PTR_W'(1);
  assign underrunEvt = stb.pop && !stb.flush && !canPop;

  always_comb begin
    if (cfg.wide)         shaped = wrData[31:8];
    else if (cfg.msbFill) shaped = {wrData[15:0], {8{wrData[15]}}};
    else                  shaped = {wrData[15:0], 8'h00};
  end

  always_ff @(posedge clk) begin
    if (pushOk && !stb.flush) mem[wrPtr] <= shaped;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (pushOk) wrPtr <= wrPtr + PTR_W'(1);
      rdPtr <= rdPtr + PTR_W'(popN);
      level <= level + LEVEL_W'(pushOk) - popN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLeft  <= '0;
      outRight <= '0;
    end else if (!stb.flush && stb.pop) begin
      if (canPop) begin
        outLeft  <= mem[rdPtr];
        outRight <= cfg.mono ? mem[rdPtr] : mem[rdPtrNext];
      end else if (!cfg.repeatLast) begin
        outLeft  <= '0;
        outRight <= '0;
      end
    end
  end
endmodule

// File: rtl/playback_sample_fifo.sv
module playback_sample_fifo
  import pbf_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              frameReq,
  output logic [23:0]       outLeft,
  output logic [23:0]       outRight,
  output logic              drq
);
  localparam int LEVEL_W = $clog2(DEPTH + 1);

  cfg_t cfg;
  strobe_t stb;
  logic [LEVEL_W-1:0] level;
  logic underrunEvt;

  pbf_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .frameReq(frameReq), .level(level), .underrunEvt(underrunEvt),
    .cfg(cfg), .stb(stb), .drq(drq), .rdData(rdData)
  );

  pbf_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfg(cfg), .wrData(wrData),
    .level(level), .outLeft(outLeft), .outRight(outRight),
    .underrunEvt(underrunEvt)
  );
endmodule

// File: rtl/pbf_chk.sv
module pbf_chk
  import pbf_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int LEVEL_W = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input cfg_t               cfg,
  input strobe_t            stb,
  input logic [LEVEL_W-1:0] level,
  input logic               drq,
  input logic [23:0]        outLeft,
  input logic [23:0]        outRight
);
  logic unusedCfg;
  assign unusedCfg = ^{cfg.wide, cfg.msbFill, cfg.trig, cfg.clrCnt};

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= LEVEL_W'(DEPTH));

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (level == LEVEL_W'(DEPTH) && stb.push && !stb.pop && !stb.flush) |=> level == LEVEL_W'(DEPTH));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> level == '0);

  // R9
  drq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.drqEn |=> !drq);

  // R5
  mono_dup_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pop && !stb.flush && cfg.mono && level != '0) |=> outLeft == outRight);

  // R6
  underrun_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pop && !stb.flush && level == '0 && !cfg.repeatLast) |=> (outLeft == '0 && outRight == '0));

  // R6
  underrun_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pop && !stb.flush && level == '0 && cfg.repeatLast) |=> ($stable(outLeft) && $stable(outRight)));
endmodule

bind playback_sample_fifo pbf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .level(level),
  .drq(drq), .outLeft(outLeft), .outRight(outRight)
);

// File: tb/playback_sample_fifo_test.sv
module playback_sample_fifo_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic        frameReq = 1'b0;
  logic [31:0] rdData;
  logic [23:0] outLeft, outRight;
  logic        drq;

  playback_sample_fifo uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .frameReq(frameReq), .outLeft(outLeft),
    .outRight(outRight), .drq(drq)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [23:0] q[$];
  logic [23:0] lastL = '0, lastR = '0;
  bit curWide, curMono, curMsb, curRep;
  logic [31:0] r;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(bit dq, bit wide, bit mono, int trig, int clr,
                                     bit msb, bit rep, bit fl);
    return 32'(fl) | (32'(dq) << 4) | (32'(wide) << 5) | (32'(mono) << 6) |
           ((32'(trig) & 32'h3f) << 8) | ((32'(clr) & 32'h3) << 21) |
           (32'(msb) << 24) | (32'(rep) << 26);
  endfunction

  function automatic logic [23:0] fmt(logic [31:0] d, bit wide, bit msb);
    if (wide) return d[31:8];
    return {d[15:0], msb ? {8{d[15]}} : 8'h00};
  endfunction

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic setCfg(bit dq, bit wide, bit mono, int trig, int clr, bit msb, bit rep);
    curWide = wide; curMono = mono; curMsb = msb; curRep = rep;
    wr(6'h04, cw(dq, wide, mono, trig, clr, msb, rep, 1'b0));
  endtask

  task automatic push(logic [31:0] d);
    wr(6'h0C, d);
    if (q.size() < 64) q.push_back(fmt(d, curWide, curMsb));
  endtask

  task automatic popFrame(string req);
    int need;
    @(negedge clk); frameReq = 1'b1;
    @(negedge clk); frameReq = 1'b0;
    need = curMono ? 1 : 2;
    if (q.size() >= need) begin
      lastL = q.pop_front();
      lastR = curMono ? lastL : q.pop_front();
    end else if (!curRep) begin
      lastL = '0; lastR = '0;
    end
    check({req, " left"}, 32'(outLeft), 32'(lastL));
    check({req, " right"}, 32'(outRight), 32'(lastR));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkFree(string req);
    rd(6'h08, r);
    check(req, r & 32'h7f, 32'(64 - q.size()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    rd(6'h04, r); check("R1 ctrl reset", r, 32'h0);
    rd(6'h08, r); check("R1 status reset", r, 32'h40);
    check("R1 drq reset", 32'(drq), 32'h0);
    check("R1 out reset", 32'({outLeft, outRight}), 32'h0);

    // R1 readback of fields
    setCfg(1'b0, 1'b1, 1'b1, 6'h2a, 2, 1'b1, 1'b1);
    rd(6'h04, r); check("R1 ctrl readback", r, cw(0, 1, 1, 6'h2a, 2, 1, 1, 0));

    // R3 narrow formatting, mono
    setCfg(1'b0, 1'b0, 1'b1, 0, 0, 1'b0, 1'b0);
    push(32'hFFFF_8001);
    setCfg(1'b0, 1'b0, 1'b1, 0, 0, 1'b1, 1'b0);
    push(32'h0000_8001);
    push(32'h1234_7001);
    popFrame("R3 zero pad");
    check("R3 zero pad literal", 32'(outLeft), 32'h800100);
    popFrame("R3 msb fill ones");
    check("R3 msb fill literal", 32'(outLeft), 32'h8001FF);
    popFrame("R3 msb fill zeros");

    // R2 wide samples
    setCfg(1'b0, 1'b1, 1'b1, 0, 0, 1'b0, 1'b0);
    push(32'hABCD_EF12);
    popFrame("R2 wide");
    check("R2 wide literal", 32'(outLeft), 32'hABCDEF);

    // R5 stereo order
    setCfg(1'b0, 1'b1, 1'b0, 0, 0, 1'b0, 1'b1);
    push(32'h1111_1100);
    push(32'h2222_2200);
    popFrame("R5 stereo");
    check("R5 stereo left literal", 32'(outLeft), 32'h111111);

    // R6 underrun with one entry in stereo, repeat policy
    push(32'h3333_3300);
    popFrame("R6 hold");
    check("R6 hold literal", 32'(outRight), 32'h222222);
    checkFree("R6 nothing consumed");
    // R7 sticky set and clear
    rd(6'h08, r); check("R7 sticky set", (r >> 7) & 1, 32'h1);
    wr(6'h08, 32'h80);
    rd(6'h08, r); check("R7 sticky cleared", (r >> 7) & 1, 32'h0);
    setCfg(1'b0, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0);
    popFrame("R6 zero policy");

    // R8 flush
    push(32'h4444_4400);
    push(32'h5555_5500);
    wr(6'h04, cw(0, 1, 0, 0, 0, 0, 0, 1));
    rd(6'h04, r); check("R8 flush reads one", r & 1, 32'h1);
    idle(1);
    rd(6'h04, r); check("R8 flush self clears", r & 1, 32'h0);
    q.delete();
    checkFree("R8 empty after flush");

    // R4 fill, overflow drop, order
    setCfg(1'b0, 1'b1, 1'b1, 0, 0, 1'b0, 1'b0);
    for (int i = 0; i < 65; i++) push(32'(i + 1) << 8);
    checkFree("R4 full");
    for (int i = 0; i < 64; i++) popFrame("R4 order");
    checkFree("R4 drained");

    // R9 / R10 DMA request hysteresis, trigger 32, clear code 3 (16)
    setCfg(1'b1, 1'b1, 1'b1, 32, 3, 1'b0, 1'b0);
    idle(2); check("R10 rise on empty", 32'(drq), 32'h1);
    for (int i = 0; i < 40; i++) push($urandom);
    idle(2); check("R10 hold in band", 32'(drq), 32'h1);
    for (int i = 0; i < 10; i++) push($urandom);
    idle(2); check("R10 drop below 16", 32'(drq), 32'h0);
    for (int i = 0; i < 6; i++) popFrame("R10 data");
    idle(2); check("R10 hold low in band", 32'(drq), 32'h0);
    for (int i = 0; i < 12; i++) popFrame("R10 data");
    idle(2); check("R10 rise at trigger", 32'(drq), 32'h1);
    for (int i = 0; i < 22; i++) push($urandom);
    setCfg(1'b1, 1'b1, 1'b1, 4, 3, 1'b0, 1'b0);
    idle(2); check("R10 drop has priority", 32'(drq), 32'h0);
    setCfg(1'b1, 1'b1, 1'b1, 4, 0, 1'b0, 1'b0);
    idle(2); check("R10 rise free 10 trig 4", 32'(drq), 32'h1);
    setCfg(1'b0, 1'b1, 1'b1, 4, 0, 1'b0, 1'b0);
    idle(1); check("R9 disabled low", 32'(drq), 32'h0);

    // Random mixed traffic
    for (int it = 0; it < 40; it++) begin
      setCfg(1'b0, 1'($urandom), 1'($urandom), 0, 0, 1'($urandom), 1'($urandom));
      for (int k = $urandom_range(0, 40); k > 0; k--) push($urandom);
      for (int k = $urandom_range(0, 30); k > 0; k--) popFrame("R5 R6 random");
      checkFree("R7 random level");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule